// File: doc/BRIEF.md
# Reconfiguration Thread Sequence Manager

This controller steps a reconfigurable operation-cell array through a programmed chain of configurations, here called threads. While the controller is idle, the host loads a small sequence table through a plain write port. Each table entry holds a logical thread number, the index of the event input that ends that thread, the index of the entry that follows, and a flag that marks the final entry. The host then pulses a start input. The controller runs entry 0 first. It then follows the next-entry links, and each move from one entry to the next is triggered by the event input that the running entry selects.

Every change of thread passes through a fixed switch phase of two cycles, during which the array is held inactive. In the first of the two cycles a reconfigure strobe is raised. From the second cycle on, the new thread number is driven to the configuration logic. An external error, or a link to an entry that was never loaded, stops the sequence with an error status. Finishing the entry that carries the final flag stops it with a done status. In both cases an interrupt stays raised until the host acknowledges it.

Top module: `thread_seq_ctrl`

## Requirements
- R1: After reset the outputs reconf, active, irq, done_flag, error_flag and thread_num are all 0. Without a start pulse the block stays idle whatever the event inputs do.
- R2: A start pulse sampled while idle, with entry 0 loaded, gives reconf=1 in the next cycle. thread_num then equals entry 0's thread field one cycle later, and active=1 one cycle after that.
- R3: Table write data fields are thread [3:0], event index [7:4], next-entry index [11:8] and final flag [12]. While active, only the event input whose number equals the running entry's event index ends the thread. Any other event input has no effect.
- R4: A thread switch lasts exactly two cycles, with active=0 in both. reconf=1 only in the first of them.
- R5: thread_num changes to the new entry's thread field in the second switch cycle. It stays constant while active.
- R6: When the selected event arrives on an entry whose final flag is 1, the next cycle shows irq=1, done_flag=1 and error_flag=0.
- R7: err_in sampled while active or switching gives irq=1 and error_flag=1 in the next cycle.
- R8: If the selected event arrives on an entry whose next-entry index names an entry that was never written, the block halts with error_flag=1. A start pulse while entry 0 has never been written does the same.
- R9: Event inputs are sampled only while active, so an event held during the two switch cycles does not end the following thread.
- R10: irq stays 1 until ack is sampled high while halted. Then irq, done_flag and error_flag return to 0 and the block is idle again.
- R11: Table writes are accepted only while idle. A write issued while halted leaves the entry unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Table write enable |
| cfg_addr | input | 4 | Table entry written |
| cfg_wdata | input | 13 | Entry record: final flag, next index, event index, thread |
| start | input | 1 | Start trigger from host |
| ack | input | 1 | Interrupt acknowledge from host |
| err_in | input | 1 | Error report from the array |
| events | input | 16 | Trigger event inputs |
| thread_num | output | 4 | Logical thread presented to configuration logic |
| reconf | output | 1 | Reconfigure strobe, first switch cycle |
| active | output | 1 | Array is executing the current thread |
| irq | output | 1 | Interrupt to host while halted |
| done_flag | output | 1 | Halted after the final entry |
| error_flag | output | 1 | Halted because of an error |

## Verification
The hardest case to reach from the ports is an event that arrives during the two switch cycles and matches the event index of the thread being switched in. Only there would a wrongly timed sampler skip a thread. The stimulus drives that event on the edge that enters the first switch cycle and holds it through the second. It removes the event just after the thread becomes active, then checks that the new thread keeps running. A write issued while halted is checked by restarting the sequence and reading entry 0's thread number back on thread_num.

// File: rtl/tseq_pkg.sv
// Shared types for the thread sequence manager.
package tseq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_RUN  = 3'd1,
        ST_SW1  = 3'd2,
        ST_SW2  = 3'd3,
        ST_HALT = 3'd4
    } seq_state_t;
endpackage

// File: rtl/tseq_table.sv
// Sequence table: one register record per entry, plus a loaded bit per entry.
// Assumes the write enable is already qualified by the caller (idle only).
// Port A reads the current entry; port B checks whether a link target was loaded.
module tseq_table #(
    parameter int ENTRIES = 16,
    parameter int REC_W   = 13,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_addr,
    input  logic [REC_W-1:0] wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [REC_W-1:0] rd_rec,
    output logic             rd_loaded,
    input  logic [IDX_W-1:0] chk_idx,
    output logic             chk_loaded
);
    logic [REC_W-1:0] rec_q [ENTRIES];
    logic [ENTRIES-1:0] loaded_q;

    // Store a record and mark the entry loaded; loaded bits clear on reset.
    always_ff @(posedge clk) begin
        for (int i = 0; i < ENTRIES; i++) begin
            if (wr_en && wr_addr == IDX_W'(i)) begin
                rec_q[i] <= wr_data;
            end
        end
        if (!rst_n) begin
            loaded_q <= '0;
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (wr_en && wr_addr == IDX_W'(i)) begin
                    loaded_q[i] <= 1'b1;
                end
            end
        end
    end

    // Combinational read of the current entry and link-target validity.
    always_comb begin
        rd_rec     = rec_q[rd_idx];
        rd_loaded  = ({1'b0, rd_idx} < (IDX_W+1)'(ENTRIES)) && loaded_q[rd_idx];
        chk_loaded = ({1'b0, chk_idx} < (IDX_W+1)'(ENTRIES)) && loaded_q[chk_idx];
    end
endmodule

// File: rtl/tseq_event_pick.sv
// Selects the one event input named by the running entry.
// Assumes the index is within range; an out-of-range index reads as no event.
module tseq_event_pick #(
    parameter int EVENTS = 16,
    localparam int EVT_W = $clog2(EVENTS)
) (
    input  logic [EVENTS-1:0] events,
    input  logic [EVT_W-1:0]  sel,
    output logic              hit
);
    logic [EVENTS-1:0] match;

    // One compare per event line, then OR-reduce.
    for (genvar g = 0; g < EVENTS; g++) begin : g_match
        assign match[g] = events[g] && (sel == EVT_W'(g));
    end
    assign hit = |match;
endmodule

// File: rtl/tseq_fsm.sv
// Sequence state machine: idle, run, two switch cycles, halt.
// Assumes table lookups are combinational, and events and errors are synchronous.
module tseq_fsm #(
    parameter int THREAD_W = 4,
    parameter int IDX_W    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                ack,
    input  logic                err_in,
    input  logic                evt_hit,
    input  logic                cur_loaded,
    input  logic                cur_last,
    input  logic [IDX_W-1:0]    cur_next,
    input  logic [THREAD_W-1:0] cur_thread,
    input  logic                next_loaded,
    output logic [IDX_W-1:0]    idx,
    output logic                wr_allow,
    output logic [THREAD_W-1:0] thread_num,
    output logic                reconf,
    output logic                active,
    output logic                irq,
    output logic                done_flag,
    output logic                error_flag
);
    import tseq_pkg::*;

    seq_state_t state_q, state_d;
    logic [IDX_W-1:0]    idx_q, idx_d;
    logic [THREAD_W-1:0] thr_q;
    logic done_q, done_d, err_q, err_d;

    // Next-state decision from state, events, errors and table contents.
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        done_d  = done_q;
        err_d   = err_q;
        unique case (state_q)
            ST_IDLE: if (start) begin
                if (cur_loaded) state_d = ST_SW1;
                else begin state_d = ST_HALT; err_d = 1'b1; end
            end
            ST_RUN: begin
                if (err_in) begin
                    state_d = ST_HALT; err_d = 1'b1;
                end else if (evt_hit) begin
                    if (cur_last) begin
                        state_d = ST_HALT; done_d = 1'b1;
                    end else if (!next_loaded) begin
                        state_d = ST_HALT; err_d = 1'b1;
                    end else begin
                        idx_d = cur_next; state_d = ST_SW1;
                    end
                end
            end
            ST_SW1: begin
                if (err_in) begin state_d = ST_HALT; err_d = 1'b1; end
                else state_d = ST_SW2;
            end
            ST_SW2: begin
                if (err_in) begin state_d = ST_HALT; err_d = 1'b1; end
                else state_d = ST_RUN;
            end
            ST_HALT: if (ack) begin
                state_d = ST_IDLE; idx_d = '0; done_d = 1'b0; err_d = 1'b0;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State, entry index and status registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            done_q  <= done_d;
            err_q   <= err_d;
        end
    end

    // Present the new thread from the second switch cycle onward.
    always_ff @(posedge clk) begin
        if (!rst_n) thr_q <= '0;
        else if (state_q == ST_SW1 && !err_in) thr_q <= cur_thread;
    end

    // Decoded outputs.
    always_comb begin
        idx        = idx_q;
        wr_allow   = (state_q == ST_IDLE);
        thread_num = thr_q;
        reconf     = (state_q == ST_SW1);
        active     = (state_q == ST_RUN);
        irq        = (state_q == ST_HALT);
        done_flag  = done_q;
        error_flag = err_q;
    end
endmodule

// File: rtl/thread_seq_ctrl.sv
// Top: sequences an operation-cell array through table-driven threads.
// Assumes the host loads the table while idle and starts at entry 0.
module thread_seq_ctrl #(
    parameter int ENTRIES  = 16,
    parameter int THREAD_W = 4,
    parameter int EVENTS   = 16,
    localparam int IDX_W   = $clog2(ENTRIES),
    localparam int EVT_W   = $clog2(EVENTS),
    localparam int REC_W   = THREAD_W + EVT_W + IDX_W + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [IDX_W-1:0]    cfg_addr,
    input  logic [REC_W-1:0]    cfg_wdata,
    input  logic                start,
    input  logic                ack,
    input  logic                err_in,
    input  logic [EVENTS-1:0]   events,
    output logic [THREAD_W-1:0] thread_num,
    output logic                reconf,
    output logic                active,
    output logic                irq,
    output logic                done_flag,
    output logic                error_flag
);
    localparam int EVT_LO  = THREAD_W;
    localparam int NEXT_LO = THREAD_W + EVT_W;
    localparam int LAST_B  = THREAD_W + EVT_W + IDX_W;

    logic [IDX_W-1:0] idx;
    logic [REC_W-1:0] rec;
    logic cur_loaded, next_loaded, evt_hit, wr_allow;

    tseq_table #(.ENTRIES(ENTRIES), .REC_W(REC_W)) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (cfg_we && wr_allow),
        .wr_addr    (cfg_addr),
        .wr_data    (cfg_wdata),
        .rd_idx     (idx),
        .rd_rec     (rec),
        .rd_loaded  (cur_loaded),
        .chk_idx    (rec[NEXT_LO +: IDX_W]),
        .chk_loaded (next_loaded)
    );

    tseq_event_pick #(.EVENTS(EVENTS)) u_pick (
        .events (events),
        .sel    (rec[EVT_LO +: EVT_W]),
        .hit    (evt_hit)
    );

    tseq_fsm #(.THREAD_W(THREAD_W), .IDX_W(IDX_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .ack         (ack),
        .err_in      (err_in),
        .evt_hit     (evt_hit),
        .cur_loaded  (cur_loaded),
        .cur_last    (rec[LAST_B]),
        .cur_next    (rec[NEXT_LO +: IDX_W]),
        .cur_thread  (rec[THREAD_W-1:0]),
        .next_loaded (next_loaded),
        .idx         (idx),
        .wr_allow    (wr_allow),
        .thread_num  (thread_num),
        .reconf      (reconf),
        .active      (active),
        .irq         (irq),
        .done_flag   (done_flag),
        .error_flag  (error_flag)
    );
endmodule

// File: rtl/tseq_checker.sv
// Port-level properties of the sequence manager, bound to the top.
module tseq_checker #(
    parameter int THREAD_W = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                ack,
    input logic                err_in,
    input logic [THREAD_W-1:0] thread_num,
    input logic                reconf,
    input logic                active,
    input logic                irq,
    input logic                done_flag,
    input logic                error_flag
);
    // R4: strobe lasts one cycle and the array stays inactive after it
    a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        reconf |=> (!reconf && !active));

    // R5: thread number holds while the array runs
    a_r5_thread_stable: assert property (@(posedge clk) disable iff (!rst_n)
        active |=> (!active || $stable(thread_num)));

    // R6: a halt reports exactly one cause
    a_r6_one_cause: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (done_flag != error_flag));

    // R7: error while running halts with error status
    a_r7_error_halts: assert property (@(posedge clk) disable iff (!rst_n)
        (active && err_in) |=> (irq && error_flag));

    // R10: interrupt held until acknowledged
    a_r10_irq_held: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !ack) |=> irq);

    // R10: acknowledge clears interrupt and status
    a_r10_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && ack) |=> (!irq && !done_flag && !error_flag));

    // R1: status bits only appear together with the interrupt
    a_r1_status_with_irq: assert property (@(posedge clk) disable iff (!rst_n)
        !irq |-> (!done_flag && !error_flag));
endmodule

bind thread_seq_ctrl tseq_checker #(.THREAD_W(THREAD_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ack        (ack),
    .err_in     (err_in),
    .thread_num (thread_num),
    .reconf     (reconf),
    .active     (active),
    .irq        (irq),
    .done_flag  (done_flag),
    .error_flag (error_flag)
);

// File: tb/thread_seq_ctrl_tb.sv
// Directed bench for thread_seq_ctrl; one task per scenario.
module thread_seq_ctrl_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [12:0] cfg_wdata = '0;
    logic        start = 1'b0, ack = 1'b0, err_in = 1'b0;
    logic [15:0] events = '0;
    logic [3:0]  thread_num;
    logic        reconf, active, irq, done_flag, error_flag;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    thread_seq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .start(start), .ack(ack), .err_in(err_in),
        .events(events), .thread_num(thread_num), .reconf(reconf),
        .active(active), .irq(irq), .done_flag(done_flag), .error_flag(error_flag)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Pack {last, next, event, thread}.
    function automatic logic [12:0] rec(input bit last, input int nxt,
                                        input int evt, input int thr);
        return {last, 4'(nxt), 4'(evt), 4'(thr)};
    endfunction

    task automatic wr(input int a, input logic [12:0] d);
        cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = d;
        step();
        cfg_we = 1'b0;
    endtask

    // Start and walk through the two switch cycles into RUN.
    task automatic do_start(input int exp_thr);
        start = 1'b1;
        step();
        start = 1'b0;
        check("R2 reconf after start", reconf, 1);
        check("R4 inactive in first switch cycle", active, 0);
        step();
        check("R2 thread in second switch cycle", thread_num, exp_thr);
        check("R4 strobe one cycle", reconf, 0);
        check("R4 inactive in second switch cycle", active, 0);
        step();
        check("R2 active after switch", active, 1);
    endtask

    task automatic do_ack();
        ack = 1'b1;
        step();
        ack = 1'b0;
        check("R10 irq cleared by ack", irq, 0);
        check("R10 done cleared", done_flag, 0);
        check("R10 error cleared", error_flag, 0);
    endtask

    task automatic t_reset();
        check("R1 reset reconf", reconf, 0);
        check("R1 reset active", active, 0);
        check("R1 reset irq", irq, 0);
        check("R1 reset flags", {done_flag, error_flag}, 0);
        check("R1 reset thread", thread_num, 0);
    endtask

    task automatic t_idle_no_start();
        events = 16'hFFFF;
        repeat (3) step();
        events = '0;
        check("R1 idle without start: active", active, 0);
        check("R1 idle without start: reconf", reconf, 0);
    endtask

    task automatic t_unloaded_start();
        start = 1'b1;
        step();
        start = 1'b0;
        check("R8 start with entry 0 unloaded: irq", irq, 1);
        check("R8 start with entry 0 unloaded: error", error_flag, 1);
        do_ack();
    endtask

    task automatic t_main_sequence();
        wr(0, rec(1'b0, 1, 2, 5));
        wr(1, rec(1'b0, 2, 7, 9));
        wr(2, rec(1'b1, 0, 1, 3));
        do_start(5);
        events = 16'h0008;                 // event 3: not selected
        repeat (3) step();
        check("R3 unselected event ignored: active", active, 1);
        check("R3 unselected event ignored: thread", thread_num, 5);
        events = 16'h0004;                 // event 2 ends entry 0
        step();
        check("R4 switch first cycle strobe", reconf, 1);
        check("R5 thread unchanged in first cycle", thread_num, 5);
        events = 16'h0080;                 // entry 1's event during switch
        step();
        check("R5 new thread in second cycle", thread_num, 9);
        check("R4 second cycle inactive", active, 0);
        step();
        events = '0;
        check("R9 running after switch", active, 1);
        step();
        check("R9 switch-time event ignored: active", active, 1);
        check("R9 switch-time event ignored: thread", thread_num, 9);
        events = 16'h0080;
        step();
        events = '0;
        check("R3 selected event switches", reconf, 1);
        step(); step();
        check("R5 third thread running", thread_num, 3);
        check("R5 third thread active", active, 1);
        events = 16'h0002;                 // final entry's event
        step();
        events = '0;
        check("R6 final entry halts: irq", irq, 1);
        check("R6 done flag", done_flag, 1);
        check("R6 no error flag", error_flag, 0);
        repeat (4) step();
        check("R10 irq held without ack", irq, 1);
        wr(0, rec(1'b0, 1, 2, 10));        // write while halted
        do_ack();
        do_start(5);
        check("R11 halted write ignored", thread_num, 5);
    endtask

    task automatic t_error_input();
        err_in = 1'b1;
        step();
        err_in = 1'b0;
        check("R7 error halts: irq", irq, 1);
        check("R7 error flag", error_flag, 1);
        check("R7 no done flag", done_flag, 0);
        do_ack();
    endtask

    task automatic t_bad_link();
        wr(0, rec(1'b0, 6, 2, 5));         // entry 6 never written
        do_start(5);
        events = 16'h0004;
        step();
        events = '0;
        check("R8 bad link halts: irq", irq, 1);
        check("R8 bad link error flag", error_flag, 1);
        check("R8 thread unchanged", thread_num, 5);
        do_ack();
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_idle_no_start();
        t_unloaded_start();
        t_main_sequence();
        t_error_input();
        t_bad_link();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule